// File: doc/BRIEF.md
# Card Attribute Configuration Register Set

This block sits on the card side of a removable storage card and holds the few configuration registers a host reaches through attribute memory space. The host uses an 8-bit read/write port with an address, a write strobe and a read enable. Through this port it selects a configuration index and picks how the card signals interrupts. It can also hold the rest of the card in reset by software. It can watch the card's internal ready line through a sticky change flag.

Three registers are decoded: the option register at 0x200, the pin replacement register at 0x204 and the socket/copy register at 0x206. The block drives the configuration index, the interrupt-mode select and a soft-reset request to the rest of the card. It also shapes an internal interrupt source into an interrupt output, either as a level or as a fixed-length pulse. The soft-reset bit is held here and survives the reset it requests. Only the hardware reset input clears this block.

Top module: `cfg_attr_regs`

## Requirements
- R1: While the active-low hardware reset is asserted, and after it is released with no access, the option register reads 0x00, the index and mode outputs are 0, soft-reset is 0, the interrupt output is 0 and the change flag is 0.
- R2: The option register at 0x200 holds soft-reset in bit 7, the interrupt mode in bit 6 (1 = level, 0 = pulse) and the configuration index in bits 3:0. A write there is visible on the outputs and in the readback from the next clock.
- R3: Writing the option register with bit 7 = 1 clears the mode bit, the index, the change flag and any running interrupt pulse, and sets the soft-reset bit. The soft-reset bit stays 1 until the host writes it to 0. While it is 1 the change flag is held at 0.
- R4: A write to the option register while soft-reset is 1 changes only bit 7. Writing bit 7 back to 0 leaves the index at 0 and the mode at pulse. A later write with bit 7 = 0 configures the card normally.
- R5: Index bits 5 and 4 always read as 0 and drive 0 on the index output, whatever data was written.
- R6: The pin replacement register at 0x204 reads with bit 5 = change flag, bits 3 and 2 = 1, bit 1 = the ready input as sampled on the previous clock, and every other bit 0.
- R7: When the ready input differs from its value at the previous clock, the change flag is 1 from the next clock. This set wins over a host write in the same cycle.
- R8: On a write to 0x204, the change flag takes bit 5 of the data only when bit 1 of the data is 1. Otherwise the flag is unchanged.
- R9: The socket/copy register at 0x206 always reads 0x00 and writes to it have no effect. Odd addresses and every other unmapped address read 0x00 and ignore writes. The read data is 0x00 whenever read enable is low.
- R10: In level mode the interrupt output equals the interrupt source as sampled on the previous clock.
- R11: In pulse mode each rising edge of the interrupt source drives the interrupt output high for PULSE_LEN clocks, starting at the next clock. A new rising edge reloads the full length.
- R12: The soft-reset output is 1 exactly while the soft-reset bit is 1 and the hardware reset input is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Hardware reset, active low, asynchronous |
| addr_i | input | ADDR_W | Attribute memory address |
| wdata_i | input | 8 | Host write data |
| we_i | input | 1 | Write strobe, one write per clock while high |
| oe_i | input | 1 | Read enable |
| rdata_o | output | 8 | Read data, 0x00 when not enabled or unmapped |
| ready_i | input | 1 | Internal ready state of the card |
| irq_src_i | input | 1 | Internal interrupt source |
| cfg_index_o | output | 6 | Configuration index, bits 5:4 always 0 |
| level_mode_o | output | 1 | 1 = level interrupt mode, 0 = pulse mode |
| soft_rst_o | output | 1 | Soft-reset request to the rest of the card |
| irq_o | output | 1 | Interrupt output, active high |

## Verification
The bench goes after writes made while soft-reset is active. A design that clears the bit along with the other fields would drop soft_rst_o at once. A design that loads the index on the write that releases it would come out of reset configured. It sets the change flag and applies a masked clear to it in the same cycle, to catch a design that gives the write priority and loses a ready edge. It also writes with the mask bit low, which catches a design that ignores the mask. Reserved index bits, odd and unmapped addresses and the socket register are all written with 0xFF. Any leak shows up in a later readback. The bench retriggers the interrupt source in the middle of a pulse, which separates a reload from a counter that runs out early or stretches.

// File: rtl/cfg_attr_pkg.sv
package cfg_attr_pkg;
  localparam int unsigned ATTR_AW = 10;
  localparam logic [ATTR_AW-1:0] OFS_OPTION = 10'h200;
  localparam logic [ATTR_AW-1:0] OFS_PINREP = 10'h204;
  localparam logic [ATTR_AW-1:0] OFS_SOCKET = 10'h206;

  typedef struct packed {
    logic       sreset;
    logic       level;
    logic [5:0] index;
  } opt_reg_t;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_OPTION,
    SEL_PINREP,
    SEL_SOCKET
  } reg_sel_e;
endpackage

// File: rtl/cfg_option_reg.sv
module cfg_option_reg
  import cfg_attr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output opt_reg_t   opt_o
);
  opt_reg_t opt_q;
  logic     unused_rsv;

  assign unused_rsv = ^wdata_i[5:4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opt_q <= '0;
    end else if (wr_i) begin
      opt_q.sreset <= wdata_i[7];
      // entering or leaving soft reset never configures the card
      if (wdata_i[7] || opt_q.sreset) begin
        opt_q.level <= 1'b0;
        opt_q.index <= '0;
      end else begin
        opt_q.level <= wdata_i[6];
        opt_q.index <= {2'b00, wdata_i[3:0]};
      end
    end
  end

  assign opt_o = opt_q;

  AST_SRESET_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && wdata_i[7] |=> opt_q.sreset && !opt_q.level && opt_q.index == '0); // R3
  AST_SRESET_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opt_q.sreset && !wr_i |=> opt_q.sreset); // R3
  AST_RELEASE_UNCONF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && opt_q.sreset |=> opt_q.index == '0 && !opt_q.level); // R4
  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> opt_q.index[5:4] == 2'b00); // R5
endmodule

// File: rtl/cfg_pin_repl.sv
module cfg_pin_repl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic ready_i,
  input  logic wr_i,
  input  logic wmask_i,
  input  logic wval_i,
  output logic ready_q_o,
  output logic cready_o
);
  logic ready_q, cready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q  <= 1'b0;
      cready_q <= 1'b0;
    end else begin
      ready_q <= ready_i;
      if (clr_i)                   cready_q <= 1'b0;
      else if (ready_i != ready_q) cready_q <= 1'b1;  // change beats host write
      else if (wr_i && wmask_i)    cready_q <= wval_i;
    end
  end

  assign ready_q_o = ready_q;
  assign cready_o  = cready_q;

  AST_CREADY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && (ready_i != ready_q) |=> cready_q); // R7
  AST_CREADY_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && wr_i && !wmask_i && (ready_i == ready_q) |=> $stable(cready_q)); // R8
  AST_CREADY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !cready_q); // R3
endmodule

// File: rtl/cfg_irq_gen.sv
module cfg_irq_gen #(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic level_i,
  input  logic src_i,
  output logic irq_o
);
  localparam int unsigned CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_LEN);

  logic             src_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;

  assign rise = src_i && !src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      src_q <= src_i;
      if (clr_i)               cnt_q <= '0;
      else if (rise)           cnt_q <= CNT_LOAD;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end
  end

  assign irq_o = level_i ? src_q : (cnt_q != '0);

  AST_PULSE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && rise |=> irq_o); // R11
  AST_PULSE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !level_i |=> level_i || !irq_o); // R3
endmodule

// File: rtl/cfg_attr_regs.sv
module cfg_attr_regs
  import cfg_attr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              we_i,
  input  logic              oe_i,
  output logic [7:0]        rdata_o,
  input  logic              ready_i,
  input  logic              irq_src_i,
  output logic [5:0]        cfg_index_o,
  output logic              level_mode_o,
  output logic              soft_rst_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_OPTION = ADDR_W'(OFS_OPTION);
  localparam logic [ADDR_W-1:0] A_PINREP = ADDR_W'(OFS_PINREP);
  localparam logic [ADDR_W-1:0] A_SOCKET = ADDR_W'(OFS_SOCKET);

  reg_sel_e sel;
  opt_reg_t opt;
  logic     ready_q, cready;
  logic [7:0] rd;

  always_comb begin
    sel = SEL_NONE;
    if (!addr_i[0]) begin
      if      (addr_i == A_OPTION) sel = SEL_OPTION;
      else if (addr_i == A_PINREP) sel = SEL_PINREP;
      else if (addr_i == A_SOCKET) sel = SEL_SOCKET;
    end
  end

  cfg_option_reg u_opt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (we_i && sel == SEL_OPTION),
    .wdata_i (wdata_i),
    .opt_o   (opt)
  );

  cfg_pin_repl u_pin (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (opt.sreset),
    .ready_i   (ready_i),
    .wr_i      (we_i && sel == SEL_PINREP),
    .wmask_i   (wdata_i[1]),
    .wval_i    (wdata_i[5]),
    .ready_q_o (ready_q),
    .cready_o  (cready)
  );

  cfg_irq_gen #(.PULSE_LEN(PULSE_LEN)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (opt.sreset),
    .level_i (opt.level),
    .src_i   (irq_src_i),
    .irq_o   (irq_o)
  );

  always_comb begin
    rd = 8'h00;
    if (oe_i) begin
      unique case (sel)
        SEL_OPTION: rd = opt;
        SEL_PINREP: rd = {2'b00, cready, 1'b0, 2'b11, ready_q, 1'b0};
        default:    rd = 8'h00;  // socket/copy and unmapped read zero
      endcase
    end
  end

  assign rdata_o      = rd;
  assign cfg_index_o  = opt.index;
  assign level_mode_o = opt.level;
  assign soft_rst_o   = opt.sreset && rst_ni;

  AST_SOFT_RST_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && sel == SEL_OPTION && wdata_i[7] |=> soft_rst_o); // R12
  AST_RD_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> rdata_o == 8'h00); // R9
endmodule

// File: tb/sim_cfg_attr_regs.sv
`timescale 1ns/1ps
module sim_cfg_attr_regs;
  localparam int PLEN = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0, oe = 1'b0, ready = 1'b0, src = 1'b0;
  logic [7:0] rdata;
  logic [5:0] idx;
  logic       lvl, srst, irq;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // reference model state
  bit m_sr, m_lvl, m_cr, m_rdy, m_src;
  int m_idx, m_cnt;

  always #4 clk = ~clk;

  cfg_attr_regs #(.ADDR_W(10), .PULSE_LEN(PLEN)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .oe_i(oe), .rdata_o(rdata), .ready_i(ready), .irq_src_i(src),
    .cfg_index_o(idx), .level_mode_o(lvl), .soft_rst_o(srst), .irq_o(irq)
  );

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h at cycle %0d", cur_req, what, act, exp, cyc);
    end
  endtask

  function automatic int exp_rdata();
    if (!oe) return 0;
    if (addr == 10'h200) return (int'(m_sr) << 7) | (int'(m_lvl) << 6) | m_idx;
    if (addr == 10'h204) return (int'(m_cr) << 5) | 8'h0C | (int'(m_rdy) << 1);
    return 0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_ni) begin
      m_sr = 0; m_lvl = 0; m_idx = 0; m_cr = 0; m_rdy = 0; m_src = 0; m_cnt = 0;
    end else begin
      bit n_sr, n_lvl, n_cr;
      int n_idx, n_cnt;
      n_sr = m_sr; n_lvl = m_lvl; n_idx = m_idx; n_cr = m_cr; n_cnt = m_cnt;
      if (we && addr == 10'h200) begin
        n_sr = wdata[7];
        if (wdata[7] || m_sr) begin n_lvl = 0; n_idx = 0; end
        else begin n_lvl = wdata[6]; n_idx = wdata & 8'h0F; end
      end
      if (m_sr) n_cr = 0;
      else if (ready != m_rdy) n_cr = 1;
      else if (we && addr == 10'h204 && wdata[1]) n_cr = wdata[5];
      if (m_sr) n_cnt = 0;
      else if (src && !m_src) n_cnt = PLEN;
      else if (m_cnt > 0) n_cnt = m_cnt - 1;
      m_sr = n_sr; m_lvl = n_lvl; m_idx = n_idx; m_cr = n_cr; m_cnt = n_cnt;
      m_rdy = ready; m_src = src;
    end
    #3;
    if (!done) begin
      chk("rdata", rdata, exp_rdata());
      chk("index", idx, m_idx);
      chk("level", lvl, m_lvl);
      chk("soft_rst", srst, m_sr && rst_ni);
      chk("irq", irq, m_lvl ? m_src : (m_cnt != 0));
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); addr = 10'(a); wdata = 8'(d); we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(int a);
    @(negedge clk); addr = 10'(a); oe = 1'b1;
    @(negedge clk); oe = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    // R1: reset state
    idle(3);
    rst_ni = 1'b1;
    idle(2); rd('h200); rd('h204);
    // R2: field layout
    cur_req = "R2";
    wr('h200, 'h4A); rd('h200); wr('h200, 'h05); rd('h200);
    // R5: reserved index bits
    cur_req = "R5";
    wr('h200, 'h3F); rd('h200); wr('h200, 'hFF & ~'h80); rd('h200);
    // R6 and R7: ready sampling and change flag
    cur_req = "R6";
    @(negedge clk); ready = 1'b1; rd('h204); idle(2); rd('h204);
    cur_req = "R7";
    @(negedge clk); ready = 1'b0; rd('h204);
    // R8: masked write
    cur_req = "R8";
    wr('h204, 'h02); rd('h204);
    wr('h204, 'h20); rd('h204);
    wr('h204, 'h22); rd('h204);
    wr('h204, 'hDD); rd('h204);
    wr('h204, 'h02); rd('h204);
    // R7: change wins over masked clear in same cycle
    cur_req = "R7";
    @(negedge clk); ready = 1'b1; addr = 10'h204; wdata = 8'h02; we = 1'b1;
    @(negedge clk); we = 1'b0; rd('h204);
    // R9: socket, odd, unmapped, read enable low
    cur_req = "R9";
    wr('h200, 'h43);
    wr('h206, 'hFF); rd('h206);
    wr('h201, 'hFF); rd('h201); rd('h200);
    wr('h205, 'h22); wr('h300, 'hFF); wr('h000, 'hFF); rd('h300); rd('h204);
    @(negedge clk); addr = 10'h200; oe = 1'b0; idle(2);
    // R10: level mode
    cur_req = "R10";
    wr('h200, 'h41);
    @(negedge clk); src = 1'b1; idle(3);
    @(negedge clk); src = 1'b0; idle(2);
    @(negedge clk); src = 1'b1; @(negedge clk); src = 1'b0; idle(2);
    // R11: pulse mode, single and retriggered
    cur_req = "R11";
    wr('h200, 'h02);
    @(negedge clk); src = 1'b1; @(negedge clk); src = 1'b0; idle(PLEN + 2);
    @(negedge clk); src = 1'b1; @(negedge clk); src = 1'b0; idle(2);
    @(negedge clk); src = 1'b1; idle(3); @(negedge clk); src = 1'b0; idle(PLEN + 2);
    // R3: soft reset clears, stays set, holds change flag
    cur_req = "R3";
    @(negedge clk); ready = 1'b0; idle(1);
    @(negedge clk); src = 1'b1; @(negedge clk); src = 1'b0;
    wr('h200, 'h85); rd('h200); rd('h204);
    @(negedge clk); ready = 1'b1; idle(2); rd('h204);
    @(negedge clk); src = 1'b1; idle(2); @(negedge clk); src = 1'b0; idle(3);
    // R12: output follows bit
    cur_req = "R12";
    idle(2);
    // R4: write during soft reset changes only bit 7
    cur_req = "R4";
    wr('h200, 'hC7); rd('h200);
    wr('h200, 'h47); rd('h200);
    wr('h200, 'h47); rd('h200);
    // R12 and R1: hardware reset during soft reset
    cur_req = "R12";
    wr('h200, 'h80); idle(1);
    @(negedge clk); rst_ni = 1'b0; idle(2);
    cur_req = "R1";
    @(negedge clk); rst_ni = 1'b1; rd('h200); rd('h204);
    idle(3);
    finish_run();
  end

  initial begin
    while (cyc < 20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, 20000);
    finish_run();
  end
endmodule